// File: doc/BRIEF.md
# Multi-flag FP branch resolver

This block resolves the floating-point "branch if any of a group of condition flags matches" instructions of a 64-bit core. It takes an instruction word with a valid strobe, the eight FP condition flags, the address of the branch and two status bits (FPU usable, 64-bit operation enabled). It recognises a two-flag form and a four-flag form, reduces the selected group of flags against a polarity bit, and produces the branch decision, the target and the address to fetch once the delay slot has executed.

Misaligned group bases are reported as unpredictable, but the block still returns a fixed result: it indexes the flags from the base as given, wrapping modulo 8. A word that is not one of these branches raises a no-match output, so that other decoders can claim it. Every result is registered and appears one cycle after the valid input.

Top module: `fp_anyflag_branch`

## Requirements
- R1: A word matches only when bits [31:26] are 010001, bits [25:21] are 01001 (two-flag form) or 01010 (four-flag form), and bit 17 is 0. A valid word that does not match raises `no_match`, and every other result output stays 0.
- R2: Two-flag form: `taken` is 1 when flag[cc] or flag[cc+1] equals the polarity bit 16. Here cc is bits [20:18].
- R3: Four-flag form: `taken` is 1 when any of flag[cc] to flag[cc+3] equals the polarity bit.
- R4: `unpredictable` is 1 when cc is odd in the two-flag form, or when cc is not a multiple of 4 in the four-flag form. Flag indices above 7 wrap modulo 8.
- R5: For an executed branch, `target` = pc + 4 + (sign-extended bits [15:0] shifted left by 2). It is 0 otherwise.
- R6: For an executed branch, `next_pc` is `target` when taken and pc + 8 when not taken.
- R7: `delay_slot` is 1 for every executed branch, taken or not.
- R8: A matching word with `fpu_en`=0 raises `exc_cop_unusable`. It suppresses all branch results, and this check takes priority over R9.
- R9: A matching word with `fpu_en`=1 and `mode64`=0 raises `exc_reserved` and suppresses all branch results.
- R10: Outputs are registered. `out_valid` follows `in_valid` one cycle later, and with no valid input every output is 0.
- R11: During and right after reset, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction word is present |
| instr | input | 32 | Instruction word |
| fcc | input | 8 | FP condition flags |
| pc | input | 64 | Address of the branch |
| fpu_en | input | 1 | FPU usable |
| mode64 | input | 1 | 64-bit operation enabled |
| out_valid | output | 1 | Registered result present |
| no_match | output | 1 | Word is not handled here |
| taken | output | 1 | Branch taken |
| delay_slot | output | 1 | Next instruction is a delay slot |
| unpredictable | output | 1 | Misaligned group base |
| exc_cop_unusable | output | 1 | Coprocessor-unusable request |
| exc_reserved | output | 1 | Reserved-instruction request |
| target | output | 64 | Branch target |
| next_pc | output | 64 | Fetch address after the delay slot |

## Verification
The bench sweeps both forms over every base, both polarities and all 256 flag vectors. This separates OR from AND reduction, a wrong group width, wrong wrap-around at the top indices, inverted polarity and wrong alignment tests. Random addresses and offsets, including negative offsets and carries across the upper bits, separate correct sign extension from zero extension. Random words with a set reserved bit or a wrong sub-opcode, together with every combination of the status bits, exercise the no-match path and the priority between the two exceptions.

// File: rtl/fab_pkg.sv
package fab_pkg;
    typedef struct packed {
        logic valid;
        logic no_match;
        logic taken;
        logic delay_slot;
        logic unpredictable;
        logic exc_cpu;
        logic exc_ri;
    } fab_flags_t;

    localparam logic [5:0] OPC_FPU  = 6'b010001;
    localparam logic [4:0] SUB_ANY2 = 5'b01001;
    localparam logic [4:0] SUB_ANY4 = 5'b01010;
endpackage

// File: rtl/fab_decode.sv
module fab_decode #(
    parameter int CC_W = 3
) (
    input  logic [31:0]     instr,
    input  logic            fpu_en,
    input  logic            mode64,
    output logic            match,
    output logic            four,
    output logic [CC_W-1:0] cc,
    output logic            tf,
    output logic [15:0]     offset,
    output logic            exc_cpu,
    output logic            exc_ri
);
    import fab_pkg::*;

    logic opc_ok, sub2, sub4;

    always_comb begin
        opc_ok  = (instr[31:26] == OPC_FPU);
        sub2    = (instr[25:21] == SUB_ANY2);
        sub4    = (instr[25:21] == SUB_ANY4);
        match   = opc_ok && (sub2 || sub4) && !instr[17];
        four    = sub4;
        cc      = instr[18 +: CC_W];
        tf      = instr[16];
        offset  = instr[15:0];
        exc_cpu = match && !fpu_en;
        exc_ri  = match && fpu_en && !mode64;
    end
endmodule

// File: rtl/fab_flag_reduce.sv
module fab_flag_reduce #(
    parameter int FLAG_N    = 8,
    parameter int MAX_GROUP = 4,
    localparam int CC_W     = $clog2(FLAG_N)
) (
    input  logic [FLAG_N-1:0] fcc,
    input  logic [CC_W-1:0]   cc,
    input  logic              tf,
    input  logic              four,
    output logic              any_hit,
    output logic              misaligned
);
    logic [MAX_GROUP-1:0] hit;

    for (genvar i = 0; i < MAX_GROUP; i++) begin : g_lane
        logic [CC_W-1:0] idx;
        always_comb begin
            idx    = cc + CC_W'(i);
            hit[i] = (fcc[idx] == tf);
        end
    end

    always_comb begin
        if (four) begin
            any_hit    = |hit;
            misaligned = (cc[1:0] != 2'b00);
        end else begin
            any_hit    = hit[0] | hit[1];
            misaligned = cc[0];
        end
    end
endmodule

// File: rtl/fab_target.sv
module fab_target #(
    parameter int ADDR_W = 64
) (
    input  logic [ADDR_W-1:0] pc,
    input  logic [15:0]       offset,
    output logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] fallthru
);
    logic [ADDR_W-1:0] disp;

    always_comb begin
        disp     = {{(ADDR_W-18){offset[15]}}, offset, 2'b00};
        target   = pc + ADDR_W'(4) + disp;
        fallthru = pc + ADDR_W'(8);
    end
endmodule

// File: rtl/fp_anyflag_branch.sv
module fp_anyflag_branch #(
    parameter int ADDR_W    = 64,
    parameter int FLAG_N    = 8,
    parameter int MAX_GROUP = 4,
    localparam int CC_W     = $clog2(FLAG_N)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [31:0]       instr,
    input  logic [FLAG_N-1:0] fcc,
    input  logic [ADDR_W-1:0] pc,
    input  logic              fpu_en,
    input  logic              mode64,
    output logic              out_valid,
    output logic              no_match,
    output logic              taken,
    output logic              delay_slot,
    output logic              unpredictable,
    output logic              exc_cop_unusable,
    output logic              exc_reserved,
    output logic [ADDR_W-1:0] target,
    output logic [ADDR_W-1:0] next_pc
);
    import fab_pkg::*;

    logic            match, four, tf, exc_cpu, exc_ri, any_hit, misaligned;
    logic [CC_W-1:0] cc;
    logic [15:0]     offset;
    logic [ADDR_W-1:0] tgt, fall;

    fab_decode #(.CC_W(CC_W)) u_dec (
        .instr(instr), .fpu_en(fpu_en), .mode64(mode64),
        .match(match), .four(four), .cc(cc), .tf(tf), .offset(offset),
        .exc_cpu(exc_cpu), .exc_ri(exc_ri)
    );

    fab_flag_reduce #(.FLAG_N(FLAG_N), .MAX_GROUP(MAX_GROUP)) u_red (
        .fcc(fcc), .cc(cc), .tf(tf), .four(four),
        .any_hit(any_hit), .misaligned(misaligned)
    );

    fab_target #(.ADDR_W(ADDR_W)) u_tgt (
        .pc(pc), .offset(offset), .target(tgt), .fallthru(fall)
    );

    fab_flags_t        flags_d, flags_q;
    logic [ADDR_W-1:0] target_d, target_q, next_d, next_q;

    always_comb begin
        flags_d       = '0;
        target_d      = '0;
        next_d        = '0;
        flags_d.valid = in_valid;
        if (in_valid) begin
            if (!match) begin
                flags_d.no_match = 1'b1;
            end else if (exc_cpu) begin
                flags_d.exc_cpu = 1'b1;
            end else if (exc_ri) begin
                flags_d.exc_ri = 1'b1;
            end else begin
                flags_d.delay_slot    = 1'b1;
                flags_d.taken         = any_hit;
                flags_d.unpredictable = misaligned;
                target_d              = tgt;
                next_d                = any_hit ? tgt : fall;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q  <= '0;
            target_q <= '0;
            next_q   <= '0;
        end else begin
            flags_q  <= flags_d;
            target_q <= target_d;
            next_q   <= next_d;
        end
    end

    assign out_valid        = flags_q.valid;
    assign no_match         = flags_q.no_match;
    assign taken            = flags_q.taken;
    assign delay_slot       = flags_q.delay_slot;
    assign unpredictable    = flags_q.unpredictable;
    assign exc_cop_unusable = flags_q.exc_cpu;
    assign exc_reserved     = flags_q.exc_ri;
    assign target           = target_q;
    assign next_pc          = next_q;

    assert_valid_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid && !taken && !delay_slot && !no_match);
    assert_taken_has_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        taken |-> delay_slot);
    assert_nomatch_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        no_match |-> !delay_slot && !exc_cop_unusable && !exc_reserved);
    assert_exc_exclusive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(exc_cop_unusable && exc_reserved));
    assert_exc_suppress_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (exc_cop_unusable || exc_reserved) |-> !delay_slot && !taken);
    assert_cpu_priority_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !fpu_en) |=> !exc_reserved);
    assert_redirect_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (delay_slot && taken) |-> next_pc == target);
endmodule

// File: tb/fp_anyflag_branch_tb.sv
module fp_anyflag_branch_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] instr = '0;
    logic [7:0]  fcc = '0;
    logic [63:0] pc = '0;
    logic        fpu_en = 1'b1;
    logic        mode64 = 1'b1;
    logic        out_valid, no_match, taken, delay_slot, unpredictable;
    logic        exc_cop_unusable, exc_reserved;
    logic [63:0] target, next_pc;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    fp_anyflag_branch dut_i (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .fcc(fcc), .pc(pc), .fpu_en(fpu_en), .mode64(mode64),
        .out_valid(out_valid), .no_match(no_match), .taken(taken),
        .delay_slot(delay_slot), .unpredictable(unpredictable),
        .exc_cop_unusable(exc_cop_unusable), .exc_reserved(exc_reserved),
        .target(target), .next_pc(next_pc)
    );

    // expected outputs packed: {valid,nomatch,taken,slot,unpred,cpu,ri}
    logic [6:0]  e_fl;
    logic [63:0] e_tgt, e_nxt;

    function automatic logic [31:0] mk(input logic four, input logic [2:0] cc,
                                       input logic tf, input logic [15:0] off);
        return {6'b010001, four ? 5'b01010 : 5'b01001, cc, 1'b0, tf, off};
    endfunction

    task automatic model(input logic v, input logic [31:0] w, input logic [7:0] f,
                         input logic [63:0] p, input logic fe, input logic m64);
        logic ok, four, hit, unp;
        logic [2:0] c;
        int n;
        e_fl = '0; e_tgt = '0; e_nxt = '0;
        if (!v) return;
        e_fl[6] = 1'b1;
        ok = (w[31:26] == 6'b010001) && (w[25:21] == 5'b01001 || w[25:21] == 5'b01010) && !w[17];
        if (!ok) begin e_fl[5] = 1'b1; return; end
        if (!fe) begin e_fl[1] = 1'b1; return; end
        if (!m64) begin e_fl[0] = 1'b1; return; end
        four = (w[25:21] == 5'b01010);
        c = w[20:18];
        n = four ? 4 : 2;
        hit = 1'b0;
        for (int k = 0; k < n; k++) if (f[(int'(c) + k) % 8] == w[16]) hit = 1'b1;
        unp = four ? (c % 4 != 0) : (c % 2 != 0);
        e_fl[4] = hit; e_fl[3] = 1'b1; e_fl[2] = unp;
        e_tgt = p + 64'd4 + (64'($signed(w[15:0])) <<< 2);
        e_nxt = hit ? e_tgt : p + 64'd8;
    endtask

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic check_all(input string req);
        chk({req, " flags"}, 64'({out_valid, no_match, taken, delay_slot, unpredictable,
                                   exc_cop_unusable, exc_reserved}), 64'(e_fl));
        chk({req, " target R5"}, target, e_tgt);
        chk({req, " next_pc R6"}, next_pc, e_nxt);
    endtask

    // drive at negedge, result registered at next posedge, sample at following negedge
    task automatic step(input string req, input logic v, input logic [31:0] w,
                        input logic [7:0] f, input logic [63:0] p,
                        input logic fe, input logic m64);
        in_valid = v; instr = w; fcc = f; pc = p; fpu_en = fe; mode64 = m64;
        model(v, w, f, p, fe, m64);
        @(negedge clk);
        check_all(req);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : stim
        int seed;
        seed = 1234;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        // R11 reset state
        model(1'b0, '0, '0, '0, 1'b1, 1'b1);
        check_all("R11 reset");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R11 after reset");

        // R2 R3 R4 exhaustive sweep of form, base, polarity, flags
        for (int fr = 0; fr < 2; fr++)
            for (int c = 0; c < 8; c++)
                for (int t = 0; t < 2; t++)
                    for (int f = 0; f < 256; f++)
                        step(fr ? "R3 four-flag" : "R2 two-flag", 1'b1,
                             mk(fr[0], c[2:0], t[0], 16'($urandom)), 8'(f),
                             {$urandom, $urandom}, 1'b1, 1'b1);

        // R4 directed: wrapped misaligned four-flag group at base 7 uses flags 7,0,1,2
        step("R4 wrap hit", 1'b1, mk(1'b1, 3'd7, 1'b1, 16'd0), 8'b0000_0100, 64'h1000, 1'b1, 1'b1);
        chk("R4 wrap taken", 64'(taken), 64'd1);
        chk("R4 unpred", 64'(unpredictable), 64'd1);
        step("R4 wrap miss", 1'b1, mk(1'b1, 3'd7, 1'b1, 16'd0), 8'b0111_1000, 64'h1000, 1'b1, 1'b1);
        chk("R4 wrap not taken", 64'(taken), 64'd0);

        // R5 R6 boundary offsets
        step("R5 neg offset", 1'b1, mk(1'b0, 3'd0, 1'b0, 16'h8000), 8'h00, 64'h0000_0000_0002_0000, 1'b1, 1'b1);
        chk("R5 neg offset value", target, 64'h0000_0000_0002_0000 + 4 - 64'h2_0000);
        step("R5 carry", 1'b1, mk(1'b0, 3'd2, 1'b1, 16'h7fff), 8'h00, 64'h0000_ffff_ffff_fffc, 1'b1, 1'b1);
        chk("R6 fall-through", next_pc, 64'h0001_0000_0000_0004);
        chk("R7 slot on not-taken", 64'(delay_slot), 64'd1);

        // R8 R9 exceptions and priority
        step("R8 cpu unusable", 1'b1, mk(1'b1, 3'd0, 1'b1, 16'd5), 8'hff, 64'h40, 1'b0, 1'b0);
        step("R8 cpu only", 1'b1, mk(1'b0, 3'd0, 1'b1, 16'd5), 8'hff, 64'h40, 1'b0, 1'b1);
        step("R9 reserved", 1'b1, mk(1'b0, 3'd4, 1'b1, 16'd5), 8'hff, 64'h40, 1'b1, 1'b0);

        // R1 no-match cases
        step("R1 reserved bit", 1'b1, mk(1'b0, 3'd0, 1'b1, 16'd1) | 32'h0002_0000, 8'hff, 64'h80, 1'b1, 1'b1);
        step("R1 other sub", 1'b1, {6'b010001, 5'b01000, 21'h0}, 8'hff, 64'h80, 1'b1, 1'b1);
        step("R1 other opcode", 1'b1, {6'b010000, 5'b01001, 21'h0}, 8'hff, 64'h80, 1'b0, 1'b0);

        // R10 idle cycles
        step("R10 idle", 1'b0, mk(1'b1, 3'd0, 1'b1, 16'd3), 8'hff, 64'h80, 1'b1, 1'b1);

        // mixed random
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] w;
            logic [2:0]  sel;
            sel = 3'($urandom);
            w = $urandom;
            if (sel < 3'd5) w = mk(sel[0], 3'($urandom), 1'($urandom), 16'($urandom));
            if (sel == 3'd5) w[31:17] = {6'b010001, ($urandom % 2) ? 5'b01010 : 5'b01001, 3'($urandom), 1'b1};
            step("R1-mix random", 1'($urandom % 8 != 0), w, 8'($urandom), {$urandom, $urandom},
                 1'($urandom % 6 != 0), 1'($urandom % 6 != 0));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule